// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. Every stored translation carries the address-space identifier (ASID) that was current when it was written. The block reports a lookup result in the same cycle that it sees a virtual page number. The hit flag is raised only when both the page number and the stored ASID equal the request's page number and the current ASID. Translations from different address spaces therefore live side by side, even when they cover the same virtual page.

On a qualified miss, the block sends a single request to an external page-table walker. While that walk is open, no other request is sent. The walker's answer is written into the cache, tagged with the ASID in effect on the cycle the answer arrives. If the current ASID changes while a walk is open, the walk is cancelled: a late answer is thrown away, and the stored translations are left as they are.

A fence port removes entries. It can remove all entries, or only those that match a page number, a given ASID value, or both. The refill slot is the lowest-numbered free entry. When no entry is free, a rotating pointer chooses the entry to overwrite.

Top module: `asid_tlb`

## Requirements
- R1: `lk_hit` is combinational and reports whether a valid entry holds both page number `lk_vpn` and ASID `cur_asid`. In that case `lk_ppn` is that entry's physical page. `lk_valid` does not affect the hit result; it only qualifies the issuing of a walk.
- R2: One virtual page can hold different physical pages under different ASIDs. Each ASID reads back its own mapping.
- R3: Suppose `lk_valid` is high, the lookup misses, and no walk is open. Then on the next cycle `walk_req_valid` is high for exactly one cycle, and `walk_req_vpn` gives the missed page. While a walk is open, further misses send no request.
- R4: A walk answer (`walk_rsp_valid`) for an open walk writes an entry. The entry holds the requested page, `walk_rsp_ppn`, and the value of `cur_asid` in the answer cycle. Once written, the entry hits from the next cycle.
- R5: A change of `cur_asid` from one cycle to the next cancels an open walk, and a later answer is ignored. Stored entries are not changed by the ASID change.
- R6: A refill goes to the lowest-numbered invalid entry. When all entries are valid, it overwrites the entry named by a rotating pointer. The pointer starts at 0 and steps by one, wrapping around, after each such overwrite.
- R7: A fence clears every entry that passes both filters. The page filter is used only when `fence_use_va` is 1; it then requires the entry's page to equal `fence_vpn`. The ASID filter is used only when `fence_use_asid` is 1; it then requires the entry's ASID to equal `fence_asid`. With both flags at 0, every entry is cleared.
- R8: A walk answer in the same cycle as `fence_valid` writes nothing and closes the open walk.
- R9: After reset, every entry is invalid, no walk is open, and `walk_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Current address-space identifier |
| lk_valid | input | 1 | Lookup qualifier; a miss with this high starts a walk |
| lk_vpn | input | VPN_W | Virtual page number looked up |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hitting entry |
| walk_req_valid | output | 1 | One-cycle walk request |
| walk_req_vpn | output | VPN_W | Page number of the open walk |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_ppn | input | PPN_W | Physical page from the walker |
| fence_valid | input | 1 | Fence strobe |
| fence_use_va | input | 1 | Apply the page filter |
| fence_vpn | input | VPN_W | Page filter value |
| fence_use_asid | input | 1 | Apply the ASID filter |
| fence_asid | input | ASID_W | ASID filter value |

## Verification
The at-most-one-hit assertion depends on the walker only answering the walk the block asked for. Because of that, a refill never duplicates a page and ASID pair that is already stored. The stimulus follows this rule by sending answers only after an observed request, and it never places an entry any other way. The stimulus also leaves `cur_asid` fixed while a walk is open, except in the cancellation case. Fences that must not disturb a refill are kept away from answer cycles, except in the one case where the two are meant to coincide.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Entry tag compare: valid and both tags equal.
  function automatic logic tag_hit(input logic vld, input logic [63:0] vpn_e,
                                   input logic [63:0] vpn_r, input logic [63:0] asid_e,
                                   input logic [63:0] asid_r);
    return vld && (vpn_e == vpn_r) && (asid_e == asid_r);
  endfunction

  // Lowest index whose valid bit is clear (0 when none is clear).
  function automatic int first_free(input logic [63:0] vld, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) if (!vld[i]) r = i;
    return r;
  endfunction

  // Rotating pointer step with wrap.
  function automatic int rr_next(input int ptr, input int n);
    return (ptr + 1 >= n) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N    = 8,
  parameter int VW   = 27,
  parameter int PW   = 20,
  parameter int AW   = 16,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] look_vpn,
  input  logic [AW-1:0] cur_asid,
  output logic          hit,
  output logic [PW-1:0] hit_ppn,
  output logic [N-1:0]  valid_vec,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [VW-1:0] wvpn,
  input  logic [PW-1:0] wppn,
  input  logic          fence_valid,
  input  logic          fence_use_va,
  input  logic [VW-1:0] fence_vpn,
  input  logic          fence_use_asid,
  input  logic [AW-1:0] fence_asid
);
  logic [N-1:0]  valid_q;
  logic [VW-1:0] vpn_q  [N];
  logic [PW-1:0] ppn_q  [N];
  logic [AW-1:0] asid_q [N];
  logic [N-1:0]  match_v;
  logic [N-1:0]  inval_v;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign match_v[g] = tlb_pkg::tag_hit(valid_q[g], 64'(vpn_q[g]), 64'(look_vpn),
                                         64'(asid_q[g]), 64'(cur_asid));
    assign inval_v[g] = fence_valid
                        && (!fence_use_va   || vpn_q[g]  == fence_vpn)
                        && (!fence_use_asid || asid_q[g] == fence_asid);

    always_ff @(posedge clk) begin
      if (!rst_n)                          valid_q[g] <= 1'b0;
      else if (inval_v[g])                 valid_q[g] <= 1'b0;
      else if (we && widx == IW'(g))       valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we && widx == IW'(g)) begin
        vpn_q[g]  <= wvpn;
        ppn_q[g]  <= wppn;
        asid_q[g] <= cur_asid;
      end
    end
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < N; i++) if (match_v[i]) hit_ppn = hit_ppn | ppn_q[i];
  end

  assign hit       = |match_v;
  assign valid_vec = valid_q;

  assert_onehot_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_v));
  assert_refill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> valid_q[$past(widx)]);
  assert_fence_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fence_valid && !fence_use_va && !fence_use_asid |=> valid_q == '0);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_vec,
  input  logic          advance,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr_q;
  logic          full;

  assign full = &valid_vec;
  assign idx  = full ? ptr_q : IW'(tlb_pkg::first_free(64'(valid_vec), N));

  always_ff @(posedge clk) begin
    if (!rst_n)               ptr_q <= '0;
    else if (advance && full) ptr_q <= IW'(tlb_pkg::rr_next(int'(ptr_q), N));
  end

  assert_free_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[idx]);
endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl #(
  parameter int VW = 27,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [VW-1:0] lk_vpn,
  input  logic          lk_hit,
  input  logic [AW-1:0] cur_asid,
  input  logic          rsp_valid,
  input  logic          fence_valid,
  output logic          walk_req,
  output logic [VW-1:0] walk_vpn,
  output logic          refill_we,
  output logic          asid_chg
);
  logic          pending_q;
  logic          req_q;
  logic [VW-1:0] vpn_q;
  logic [AW-1:0] asid_q;
  logic          issue;
  logic          accept;

  assign asid_chg  = cur_asid != asid_q;
  assign issue     = lk_valid && !lk_hit && !pending_q && !asid_chg;
  assign accept    = rsp_valid && pending_q && !asid_chg;
  assign refill_we = accept && !fence_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      req_q     <= 1'b0;
      vpn_q     <= '0;
      asid_q    <= '0;
    end else begin
      asid_q <= cur_asid;
      req_q  <= issue;
      if (issue) vpn_q <= lk_vpn;
      if (asid_chg || accept) pending_q <= 1'b0;
      else if (issue)         pending_q <= 1'b1;
    end
  end

  assign walk_req = req_q;
  assign walk_vpn = vpn_q;

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_no_req_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> !req_q);
  assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asid_chg |=> !pending_q);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              walk_req_valid,
  output logic [VPN_W-1:0]  walk_req_vpn,
  input  logic              walk_rsp_valid,
  input  logic [PPN_W-1:0]  walk_rsp_ppn,
  input  logic              fence_valid,
  input  logic              fence_use_va,
  input  logic [VPN_W-1:0]  fence_vpn,
  input  logic              fence_use_asid,
  input  logic [ASID_W-1:0] fence_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim;
  logic               refill_we;
  logic               asid_chg;

  tlb_walk_ctrl #(.VW(VPN_W), .AW(ASID_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .cur_asid(cur_asid), .rsp_valid(walk_rsp_valid), .fence_valid(fence_valid),
    .walk_req(walk_req_valid), .walk_vpn(walk_req_vpn), .refill_we(refill_we),
    .asid_chg(asid_chg));

  tlb_victim_sel #(.N(ENTRIES), .IW(IDX_W)) u_vict (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .advance(refill_we), .idx(victim));

  tlb_entry_array #(.N(ENTRIES), .VW(VPN_W), .PW(PPN_W), .AW(ASID_W), .IW(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .look_vpn(lk_vpn), .cur_asid(cur_asid), .hit(lk_hit),
    .hit_ppn(lk_ppn), .valid_vec(valid_vec), .we(refill_we), .widx(victim),
    .wvpn(walk_req_vpn), .wppn(walk_rsp_ppn), .fence_valid(fence_valid),
    .fence_use_va(fence_use_va), .fence_vpn(fence_vpn), .fence_use_asid(fence_use_asid),
    .fence_asid(fence_asid));

  assert_asid_keeps_entries_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asid_chg && !fence_valid |=> valid_vec == $past(valid_vec));
  assert_fence_blocks_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fence_valid && walk_rsp_valid && !fence_use_va && !fence_use_asid |=> !lk_hit || !rst_n
      || valid_vec == '0);
endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  localparam int VW = 27, PW = 20, AW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] cur_asid = 0;
  logic          lk_valid = 0;
  logic [VW-1:0] lk_vpn = 0;
  logic          lk_hit;
  logic [PW-1:0] lk_ppn;
  logic          walk_req_valid;
  logic [VW-1:0] walk_req_vpn;
  logic          walk_rsp_valid = 0;
  logic [PW-1:0] walk_rsp_ppn = 0;
  logic          fence_valid = 0, fence_use_va = 0, fence_use_asid = 0;
  logic [VW-1:0] fence_vpn = 0;
  logic [AW-1:0] fence_asid = 0;

  int checks = 0, fails = 0;
  logic [VW-1:0] expq[$];

  always #2.5 clk = ~clk;

  asid_tlb u0 (.*);

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: every walk request must match the next expected page.
  always @(negedge clk) begin
    if (rst_n && walk_req_valid) begin
      if (expq.size() == 0) check("R3", "unexpected walk request", 64'(walk_req_vpn), 64'hDEAD);
      else check("R3", "walk request page", 64'(walk_req_vpn), 64'(expq.pop_front()));
    end
  end

  task automatic probe(input string req, input logic [VW-1:0] vpn, input logic eh,
                       input logic [PW-1:0] ep);
    @(negedge clk);
    lk_vpn = vpn;
    #1;
    check(req, "hit", 64'(lk_hit), 64'(eh));
    if (eh) check(req, "ppn", 64'(lk_ppn), 64'(ep));
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn);
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn; expq.push_back(vpn);
    @(negedge clk);
    lk_valid = 0; walk_rsp_valid = 1; walk_rsp_ppn = ppn;
    @(negedge clk);
    walk_rsp_valid = 0;
  endtask

  task automatic fence(input logic uva, input logic [VW-1:0] v, input logic uas,
                       input logic [AW-1:0] a);
    @(negedge clk);
    fence_valid = 1; fence_use_va = uva; fence_vpn = v; fence_use_asid = uas; fence_asid = a;
    @(negedge clk);
    fence_valid = 0; fence_use_va = 0; fence_use_asid = 0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    @(negedge clk);
    check("R9", "walk_req after reset", 64'(walk_req_valid), 0);
    probe("R9", 27'h100, 0, 0);

    // R1 / R4: basic refill and lookup under ASID 1
    cur_asid = 1;
    fill(27'h100, 20'hA1);
    probe("R4", 27'h100, 1, 20'hA1);
    probe("R1", 27'h101, 0, 0);

    // R2: same page, other ASID
    cur_asid = 2;
    probe("R1", 27'h100, 0, 0);
    fill(27'h100, 20'hB2);
    probe("R2", 27'h100, 1, 20'hB2);
    cur_asid = 1;
    probe("R2", 27'h100, 1, 20'hA1);

    // R5: ASID change cancels open walk, late answer ignored
    @(negedge clk);
    lk_valid = 1; lk_vpn = 27'h200; expq.push_back(27'h200);
    @(negedge clk);
    lk_valid = 0; cur_asid = 3;
    @(negedge clk);
    walk_rsp_valid = 1; walk_rsp_ppn = 20'hCC;
    @(negedge clk);
    walk_rsp_valid = 0;
    probe("R5", 27'h200, 0, 0);
    cur_asid = 1;
    probe("R5", 27'h200, 0, 0);
    probe("R5", 27'h100, 1, 20'hA1);

    // R4: tag is the ASID current at refill
    cur_asid = 4;
    fill(27'h300, 20'h33);
    probe("R4", 27'h300, 1, 20'h33);
    cur_asid = 1;
    probe("R4", 27'h300, 0, 0);

    // R8: answer together with a fence is dropped, walk closed
    @(negedge clk);
    lk_valid = 1; lk_vpn = 27'h400; expq.push_back(27'h400);
    @(negedge clk);
    lk_valid = 0; walk_rsp_valid = 1; walk_rsp_ppn = 20'h44;
    fence_valid = 1; fence_use_va = 1; fence_vpn = 27'h999;
    @(negedge clk);
    walk_rsp_valid = 0; fence_valid = 0; fence_use_va = 0;
    probe("R8", 27'h400, 0, 0);
    fill(27'h401, 20'h41);
    probe("R8", 27'h401, 1, 20'h41);

    // R7: filtered fences
    fence(0, 0, 1, 16'd2);
    probe("R7", 27'h100, 1, 20'hA1);
    cur_asid = 2;
    probe("R7", 27'h100, 0, 0);
    cur_asid = 1;
    fence(1, 27'h401, 0, 0);
    probe("R7", 27'h401, 0, 0);
    fence(1, 27'h300, 1, 16'd1);
    cur_asid = 4;
    probe("R7", 27'h300, 1, 20'h33);
    fence(0, 0, 0, 0);
    probe("R7", 27'h300, 0, 0);
    cur_asid = 1;
    probe("R7", 27'h100, 0, 0);

    // R3: no second request while a walk is open
    cur_asid = 6;
    @(negedge clk);
    lk_valid = 1; lk_vpn = 27'h700; expq.push_back(27'h700);
    @(negedge clk);
    lk_vpn = 27'h701;
    @(negedge clk);
    @(negedge clk);
    lk_valid = 0; walk_rsp_valid = 1; walk_rsp_ppn = 20'h77;
    @(negedge clk);
    walk_rsp_valid = 0;
    probe("R3", 27'h700, 1, 20'h77);
    probe("R3", 27'h701, 0, 0);
    fence(0, 0, 0, 0);

    // R6: placement and rotating replacement
    cur_asid = 5;
    for (int i = 0; i < 8; i++) fill(27'h500 + 27'(i), 20'h50 + 20'(i));
    fill(27'h600, 20'h60);
    probe("R6", 27'h500, 0, 0);
    probe("R6", 27'h501, 1, 20'h51);
    probe("R6", 27'h600, 1, 20'h60);
    fill(27'h601, 20'h61);
    probe("R6", 27'h501, 0, 0);
    fence(1, 27'h503, 0, 0);
    fill(27'h602, 20'h62);
    probe("R6", 27'h502, 1, 20'h52);
    probe("R6", 27'h602, 1, 20'h62);
    fill(27'h603, 20'h63);
    probe("R6", 27'h502, 0, 0);
    probe("R6", 27'h504, 1, 20'h54);
    probe("R6", 27'h603, 1, 20'h63);

    repeat (2) @(negedge clk);
    check("R3", "pending expected requests", 64'(expq.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule